// File: doc/BRIEF.md
# Cache Maintenance Command Queue

This block is the register front end of an outer-cache maintenance engine that several CPUs share over one simple register bus. A CPU stages a maintenance command by writing a mode word and, where the command needs them, a start address, a byte size and a way mask. It then reads its own registration-result register. That read commits the staged command into an in-order queue, or reports why the command was refused. The block passes queued commands one at a time to an abstract executor through a request/done handshake. It keeps a completion record for each CPU separately.

The staging registers are shared, and only one CPU may hold them at a time. The first CPU that writes the mode register while they are free becomes the owner. Ownership ends when that same CPU reads its registration result. A primitive register takes two codes. One starts a drain sync, whose progress can be read back. The other pulses a prefetch-buffer flush.

Top module: `mcq_top`

## Requirements
- R1: After reset no CPU owns the staging registers and the queue is empty. `ex_req`, `rd_valid`, `sync_pulse` and `pfb_flush` are low, and every per-CPU status and result reads zero.
- R2: Register index 0 is the mode word, 1 the address, 2 the size and 3 the way mask. A mode write while no CPU is the owner makes the writer the owner, stores the mode and zeroes the staged address, size and way mask. The owner may overwrite any of the four. A read of indices 0 to 3 or 7 returns zero. Writes to index 7 have no effect.
- R3: A write to indices 0 to 3 from a CPU that is not the owner changes nothing staged. It leaves the owner in place and sets bit 0 (other failure) in that CPU's pending result.
- R4: When the owner reads index 4 (registration result), ownership is released. If the queue already held DEPTH entries at that edge, the command is dropped and the read returns bit 1 (queue full). Otherwise the command is queued and bit 1 reads 0. A pop in the same cycle does not free a slot.
- R5: A read of index 4 returns that CPU's pending bit 0 together with the commit outcome, then clears the pending bit. A second read returns zero.
- R6: Commands reach the executor in arrival order and one at a time. `ex_req` rises the cycle after an entry is queued while the executor is idle. It stays high with stable fields until a cycle with `ex_done`, and then drops for at least one cycle.
- R7: The executor sees the staged address and size only if mode bits 18:17 equal 0 (range scope). Otherwise it sees zero. It sees the way mask only if mode bits 22:21 equal 2 (way target). Otherwise it sees zero. The mode word is passed unchanged.
- R8: Index 4 and index 5 have one instance per CPU. A read of index 5 returns bit 0 = this CPU has commands waiting in the queue, bit 1 = the executor is running this CPU's command, bit 2 = end flag.
- R9: On an `ex_done` cycle, the end flag of the issuing CPU is set if bit 15 of that command's mode was 1. No other CPU's flag changes, and a command with bit 15 clear sets no flag.
- R10: A write to index 5 with bit 2 = 1 clears the writer's end flag. A write with bit 2 = 0 changes nothing. If a set and a clear meet in one cycle, the flag ends up set.
- R11: Writing 8 to index 6 gives one `sync_pulse` cycle and raises a drain flag. The flag falls once the queue is empty and the executor idle, and a read of index 6 returns it in bit 0. Writing 9 gives one `pfb_flush` cycle. Any other value written there does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Id of the accessing CPU |
| bus_reg | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| ex_req | output | 1 | A command is presented to the executor |
| ex_cpu | output | CPU_W | Issuing CPU of the presented command |
| ex_mode | output | 32 | Mode word of the presented command |
| ex_addr | output | AW | Start address (range scope only) |
| ex_size | output | AW | Byte size (range scope only) |
| ex_ways | output | WAY_W | Way mask (way target only) |
| ex_done | input | 1 | Executor finished the presented command |
| sync_pulse | output | 1 | Drain-sync request pulse |
| pfb_flush | output | 1 | Prefetch-buffer flush pulse |

## Verification
Two things can hit one CPU's end flag in the same cycle: the executor's done for a command that asked for notification, and that CPU's write-1-to-clear. The bench holds a notifying command at the executor. It then raises done on exactly the cycle of the clear write and reads the completion status afterwards. Set-wins gives 4, and the bench's cycle model computes that value on its own. The same model judges the full-queue case on every clock: a commit that meets a queue of DEPTH entries must be refused even when the executor takes the head entry on that edge.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
   localparam int BUS_W = 32;

   // register indices seen on the bus
   typedef enum logic [2:0] {
      RG_MODE   = 3'd0,
      RG_ADDR   = 3'd1,
      RG_SIZE   = 3'd2,
      RG_WAYS   = 3'd3,
      RG_SETRES = 3'd4,
      RG_DONE   = 3'd5,
      RG_PRIM   = 3'd6,
      RG_NONE   = 3'd7
   } reg_e;

   // mode word fields
   localparam int MB_NOTIFY   = 15;
   localparam int MB_SCOPE_LO = 17;
   localparam int MB_TGT_LO   = 21;
   localparam logic [1:0] SCOPE_RANGE = 2'd0;
   localparam logic [1:0] TGT_WAY     = 2'd2;

   // primitive codes
   localparam logic [BUS_W-1:0] PRIM_SYNC = 32'd8;
   localparam logic [BUS_W-1:0] PRIM_PFB  = 32'd9;

   // completion status bit used by the clear write
   localparam int ST_END = 2;
endpackage

// File: rtl/mcq_fifo.sv
module mcq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rp, wp;
   logic [CW-1:0] cnt;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= bump(wp);
         if (pop)  rp <= bump(rp);
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   assign head  = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/mcq_exec.sv
module mcq_exec #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         avail,
   input  logic [W-1:0] head,
   input  logic         done,
   output logic         take,
   output logic         busy,
   output logic         fin,
   output logic [W-1:0] cur
);
   assign take = avail && !busy;
   assign fin  = busy && done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cur  <= '0;
      end else if (take) begin
         busy <= 1'b1;
         cur  <= head;
      end else if (fin) begin
         busy <= 1'b0;
      end
   end
endmodule

// File: rtl/mcq_cpu_stat.sv
module mcq_cpu_stat #(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       q_in,
   input  logic       q_out,
   input  logic       run_me,
   input  logic       end_set,
   input  logic       end_clr,
   input  logic       fail_set,
   input  logic       res_take,
   output logic       oe_pend,
   output logic [2:0] stat
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] qcnt;
   logic          ef;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qcnt    <= '0;
         ef      <= 1'b0;
         oe_pend <= 1'b0;
      end else begin
         qcnt <= qcnt + CW'(q_in) - CW'(q_out);
         // R10: a set arriving with a clear wins
         if (end_set)      ef <= 1'b1;
         else if (end_clr) ef <= 1'b0;
         // R5: the read returns the result and clears it
         if (res_take)      oe_pend <= 1'b0;
         else if (fail_set) oe_pend <= 1'b1;
      end
   end

   assign stat = {ef, run_me, (qcnt != '0)};
endmodule

// File: rtl/mcq_top.sv
module mcq_top
   import mcq_pkg::*;
#(
   parameter int NCPU  = 2,
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int WAY_W = 8,
   localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_en,
   input  logic             bus_wr,
   input  logic [CPU_W-1:0] bus_cpu,
   input  logic [2:0]       bus_reg,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic             rd_valid,
   output logic [BUS_W-1:0] rd_data,
   output logic             ex_req,
   output logic [CPU_W-1:0] ex_cpu,
   output logic [BUS_W-1:0] ex_mode,
   output logic [AW-1:0]    ex_addr,
   output logic [AW-1:0]    ex_size,
   output logic [WAY_W-1:0] ex_ways,
   input  logic             ex_done,
   output logic             sync_pulse,
   output logic             pfb_flush
);
   // elaboration-time parameter checks
   if (NCPU < 1)               begin : g_bad_ncpu  $error("NCPU must be at least 1"); end
   if (DEPTH < 2)              begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (AW < 1 || AW > BUS_W)   begin : g_bad_aw    $error("AW must lie in 1..32"); end
   if (WAY_W < 1 || WAY_W > BUS_W) begin : g_bad_way $error("WAY_W must lie in 1..32"); end

   typedef struct packed {
      logic [CPU_W-1:0] cpu;
      logic [BUS_W-1:0] mode;
      logic [AW-1:0]    addr;
      logic [AW-1:0]    size;
      logic [WAY_W-1:0] ways;
   } ent_t;
   localparam int EW = $bits(ent_t);

   reg_e rsel;
   logic wr_any, rd_any, is_own, mode_ok, wr_mode, wr_stg, commit, push;
   logic fail_oth, q_full, q_empty, take, busy, fin, cpu_ok;
   logic own_v;
   logic [CPU_W-1:0] own_id;
   logic [BUS_W-1:0] stg_mode;
   logic [AW-1:0]    stg_addr, stg_size;
   logic [WAY_W-1:0] stg_ways;
   logic sync_pend;
   ent_t new_e, head_e, cur_e;
   logic [EW-1:0] head_v, cur_v;
   logic          oe_v [NCPU];
   logic [2:0]    st_v [NCPU];
   logic [BUS_W-1:0] rnext;

   assign rsel     = reg_e'(bus_reg);
   assign wr_any   = bus_en && bus_wr;
   assign rd_any   = bus_en && !bus_wr;
   assign is_own   = own_v && (own_id == bus_cpu);
   assign mode_ok  = !own_v || is_own;
   assign wr_mode  = wr_any && (rsel == RG_MODE);
   assign wr_stg   = wr_any && (rsel == RG_ADDR || rsel == RG_SIZE || rsel == RG_WAYS);
   assign commit   = rd_any && (rsel == RG_SETRES) && is_own;
   assign push     = commit && !q_full;                 // R4
   assign fail_oth = (wr_mode && !mode_ok) || (wr_stg && !is_own); // R3
   assign cpu_ok   = (int'(bus_cpu) < NCPU);

   // staging and ownership (R2, R3, R4)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_v    <= 1'b0;
         own_id   <= '0;
         stg_mode <= '0;
         stg_addr <= '0;
         stg_size <= '0;
         stg_ways <= '0;
      end else begin
         if (wr_mode && mode_ok) begin
            own_v    <= 1'b1;
            own_id   <= bus_cpu;
            stg_mode <= bus_wdata;
            if (!own_v) begin
               stg_addr <= '0;
               stg_size <= '0;
               stg_ways <= '0;
            end
         end else if (commit) begin
            own_v <= 1'b0;
         end
         if (wr_stg && is_own) begin
            case (rsel)
               RG_ADDR: stg_addr <= bus_wdata[AW-1:0];
               RG_SIZE: stg_size <= bus_wdata[AW-1:0];
               RG_WAYS: stg_ways <= bus_wdata[WAY_W-1:0];
               default: ;
            endcase
         end
      end
   end

   // R7: fields that the scope and target do not use are zeroed
   always_comb begin
      new_e.cpu  = own_id;
      new_e.mode = stg_mode;
      new_e.addr = (stg_mode[MB_SCOPE_LO+:2] == SCOPE_RANGE) ? stg_addr : '0;
      new_e.size = (stg_mode[MB_SCOPE_LO+:2] == SCOPE_RANGE) ? stg_size : '0;
      new_e.ways = (stg_mode[MB_TGT_LO+:2] == TGT_WAY) ? stg_ways : '0;
   end

   mcq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(take), .din(EW'(new_e)),
      .head(head_v), .empty(q_empty), .full(q_full)
   );

   mcq_exec #(.W(EW)) u_exec (
      .clk(clk), .rst_n(rst_n), .avail(!q_empty), .head(head_v), .done(ex_done),
      .take(take), .busy(busy), .fin(fin), .cur(cur_v)
   );

   assign head_e = ent_t'(head_v);
   assign cur_e  = ent_t'(cur_v);

   for (genvar i = 0; i < NCPU; i++) begin : g_cpu
      logic me, mine_cur;
      assign me       = (bus_cpu == CPU_W'(i));
      assign mine_cur = (cur_e.cpu == CPU_W'(i));
      mcq_cpu_stat #(.DEPTH(DEPTH)) u_stat (
         .clk(clk), .rst_n(rst_n),
         .q_in(push && (own_id == CPU_W'(i))),
         .q_out(take && (head_e.cpu == CPU_W'(i))),
         .run_me(busy && mine_cur),
         .end_set(fin && mine_cur && cur_e.mode[MB_NOTIFY]),   // R9
         .end_clr(wr_any && (rsel == RG_DONE) && me && bus_wdata[ST_END]),
         .fail_set(fail_oth && me),
         .res_take(rd_any && (rsel == RG_SETRES) && me),
         .oe_pend(oe_v[i]), .stat(st_v[i])
      );
   end

   // read mux (R5, R8, R11)
   always_comb begin
      rnext = '0;
      if (cpu_ok) begin
         case (rsel)
            RG_SETRES: rnext = {{(BUS_W-2){1'b0}}, (is_own && q_full), oe_v[bus_cpu]};
            RG_DONE:   rnext = {{(BUS_W-3){1'b0}}, st_v[bus_cpu]};
            RG_PRIM:   rnext = {{(BUS_W-1){1'b0}}, sync_pend};
            default:   rnext = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         sync_pulse <= 1'b0;
         pfb_flush  <= 1'b0;
         sync_pend  <= 1'b0;
      end else begin
         rd_valid   <= rd_any;
         rd_data    <= rnext;
         sync_pulse <= wr_any && (rsel == RG_PRIM) && (bus_wdata == PRIM_SYNC);
         pfb_flush  <= wr_any && (rsel == RG_PRIM) && (bus_wdata == PRIM_PFB);
         if (wr_any && (rsel == RG_PRIM) && (bus_wdata == PRIM_SYNC)) sync_pend <= 1'b1;
         else if (q_empty && !busy)                                 sync_pend <= 1'b0;
      end
   end

   assign ex_req  = busy;
   assign ex_cpu  = cur_e.cpu;
   assign ex_mode = cur_e.mode;
   assign ex_addr = cur_e.addr;
   assign ex_size = cur_e.size;
   assign ex_ways = cur_e.ways;
endmodule

// File: rtl/mcq_top_chk.sv
module mcq_top_chk #(
   parameter int NCPU  = 2,
   parameter int AW    = 32,
   parameter int WAY_W = 8,
   localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_en,
   input logic             bus_wr,
   input logic [2:0]       bus_reg,
   input logic [31:0]      bus_wdata,
   input logic             rd_valid,
   input logic [31:0]      rd_data,
   input logic             ex_req,
   input logic [CPU_W-1:0] ex_cpu,
   input logic [31:0]      ex_mode,
   input logic [AW-1:0]    ex_addr,
   input logic [AW-1:0]    ex_size,
   input logic [WAY_W-1:0] ex_ways,
   input logic             ex_done,
   input logic             sync_pulse,
   input logic             pfb_flush
);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ex_req && !ex_done |=> ex_req && $stable(ex_mode) && $stable(ex_cpu) && $stable(ex_addr));

   a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ex_req && ex_done |=> !ex_req);

   a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
      ex_req && (ex_mode[18:17] != 2'd0) |-> (ex_addr == '0) && (ex_size == '0));

   a_r7_way: assert property (@(posedge clk) disable iff (!rst_n)
      ex_req && (ex_mode[22:21] != 2'd2) |-> (ex_ways == '0));

   a_r11_sync: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> $past(bus_en && bus_wr && bus_reg == 3'd6 && bus_wdata == 32'd8));

   a_r11_pfb: assert property (@(posedge clk) disable iff (!rst_n)
      pfb_flush |-> $past(bus_en && bus_wr && bus_reg == 3'd6 && bus_wdata == 32'd9));

   a_r1_rdv: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(bus_en && !bus_wr));

   a_r4_setres: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && $past(bus_reg == 3'd4) |-> (rd_data[31:2] == '0));
endmodule

bind mcq_top mcq_top_chk #(.NCPU(NCPU), .AW(AW), .WAY_W(WAY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_reg(bus_reg),
   .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .ex_req(ex_req),
   .ex_cpu(ex_cpu), .ex_mode(ex_mode), .ex_addr(ex_addr), .ex_size(ex_size),
   .ex_ways(ex_ways), .ex_done(ex_done), .sync_pulse(sync_pulse), .pfb_flush(pfb_flush)
);

// File: tb/tb_mcq_top.sv
`timescale 1ns/1ps
module tb_mcq_top;
   localparam int NCPU = 2, DEPTH = 4, AW = 32, WAY_W = 8, CPU_W = 1, LAT = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_en = 0, bus_wr = 0;
   logic [CPU_W-1:0] bus_cpu = '0;
   logic [2:0]  bus_reg = '0;
   logic [31:0] bus_wdata = '0;
   logic rd_valid, ex_req, ex_done = 1'b0, sync_pulse, pfb_flush;
   logic [31:0] rd_data, ex_mode;
   logic [CPU_W-1:0] ex_cpu;
   logic [AW-1:0] ex_addr, ex_size;
   logic [WAY_W-1:0] ex_ways;

   always #10 clk = ~clk;   // 50 MHz

   mcq_top #(.NCPU(NCPU), .DEPTH(DEPTH), .AW(AW), .WAY_W(WAY_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
      .bus_reg(bus_reg), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .ex_req(ex_req), .ex_cpu(ex_cpu), .ex_mode(ex_mode), .ex_addr(ex_addr),
      .ex_size(ex_size), .ex_ways(ex_ways), .ex_done(ex_done),
      .sync_pulse(sync_pulse), .pfb_flush(pfb_flush));

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit finished = 0, auto_done = 1, man_done = 0;
   int hi = 0;

   // ---------------- reference model ----------------
   typedef struct { int cpu; logic [31:0] mode, addr, size; logic [WAY_W-1:0] ways; } ent_t;
   ent_t q[$];
   ent_t cur;
   int own;
   logic [31:0] sm, sa, ss;
   logic [WAY_W-1:0] sw;
   bit m_busy, spend;
   bit res [NCPU];
   bit ef  [NCPU];
   bit e_rdv, e_sync, e_pf;
   logic [31:0] e_rd;
   int last_rg;

   task automatic m_reset();
      q.delete(); own = -1; sm = 0; sa = 0; ss = 0; sw = 0; m_busy = 0; spend = 0;
      for (int i = 0; i < NCPU; i++) begin res[i] = 0; ef[i] = 0; end
      e_rdv = 0; e_rd = 0; e_sync = 0; e_pf = 0; last_rg = 0;
      cur = '{0, 0, 0, 0, 0};
   endtask

   task automatic m_step();
      int c, qn0, rg;
      bit rdo, wro, full0, busy0, fin, take, anyq;
      ent_t ne;
      c = int'(bus_cpu); rg = int'(bus_reg);
      rdo = bus_en && !bus_wr; wro = bus_en && bus_wr;
      qn0 = q.size(); full0 = (qn0 == DEPTH); busy0 = m_busy;
      e_rdv = rdo; e_rd = 0; last_rg = rg;
      if (rdo) begin
         anyq = 0;
         foreach (q[k]) if (q[k].cpu == c) anyq = 1;
         if (rg == 4) e_rd = {30'd0, (own == c) && full0, res[c]};
         else if (rg == 5) e_rd = {29'd0, ef[c], busy0 && cur.cpu == c, anyq};
         else if (rg == 6) e_rd = {31'd0, spend};
      end
      e_sync = wro && rg == 6 && bus_wdata == 32'd8;
      e_pf   = wro && rg == 6 && bus_wdata == 32'd9;
      if (e_sync) spend = 1; else if (qn0 == 0 && !busy0) spend = 0;
      fin  = busy0 && ex_done;
      take = !busy0 && qn0 > 0;
      if (wro && rg == 5 && bus_wdata[2]) ef[c] = 0;
      if (fin && cur.mode[15]) ef[cur.cpu] = 1;
      if (take) begin cur = q.pop_front(); m_busy = 1; end
      else if (fin) m_busy = 0;
      if (rdo && rg == 4) begin
         if (own == c) begin
            if (!full0) begin
               ne.cpu = c; ne.mode = sm;
               ne.addr = (sm[18:17] == 0) ? sa : 0;
               ne.size = (sm[18:17] == 0) ? ss : 0;
               ne.ways = (sm[22:21] == 2) ? sw : 0;
               q.push_back(ne);
            end
            own = -1;
         end
         res[c] = 0;
      end
      if (wro && rg == 0) begin
         if (own < 0) begin own = c; sm = bus_wdata; sa = 0; ss = 0; sw = 0; end
         else if (own == c) sm = bus_wdata;
         else res[c] = 1;
      end
      if (wro && rg >= 1 && rg <= 3) begin
         if (own == c) begin
            if (rg == 1) sa = bus_wdata; else if (rg == 2) ss = bus_wdata; else sw = bus_wdata[WAY_W-1:0];
         end else res[c] = 1;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_reset(); else m_step();
   end

   // ---------------- comparison ----------------
   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         cmp("R1 ex_req in reset", 32'(ex_req), 0);
         cmp("R1 rd_valid in reset", 32'(rd_valid), 0);
         cmp("R1 sync in reset", 32'(sync_pulse | pfb_flush), 0);
      end else if (!finished) begin
         cmp("R6 ex_req", 32'(ex_req), 32'(m_busy));
         if (m_busy) begin
            cmp("R6 ex_cpu", 32'(ex_cpu), 32'(cur.cpu));
            cmp("R6 R7 ex_mode", ex_mode, cur.mode);
            cmp("R2 R7 ex_addr", ex_addr, cur.addr);
            cmp("R2 R7 ex_size", ex_size, cur.size);
            cmp("R7 ex_ways", 32'(ex_ways), 32'(cur.ways));
         end
         cmp("R1 rd_valid", 32'(rd_valid), 32'(e_rdv));
         if (e_rdv) begin
            if (last_rg == 4)      cmp("R3 R4 R5 setres", rd_data, e_rd);
            else if (last_rg == 5) cmp("R8 R9 R10 donestat", rd_data, e_rd);
            else if (last_rg == 6) cmp("R11 prim", rd_data, e_rd);
            else                   cmp("R2 other read", rd_data, e_rd);
         end
         cmp("R11 sync_pulse", 32'(sync_pulse), 32'(e_sync));
         cmp("R11 pfb_flush", 32'(pfb_flush), 32'(e_pf));
      end
   end

   // executor stand-in
   always @(negedge clk) begin
      #1;
      if (auto_done) begin
         if (ex_req && !ex_done) begin
            if (hi >= LAT) begin ex_done = 1; hi = 0; end else hi++;
         end else ex_done = 0;
      end else ex_done = man_done;
   end

   // ---------------- stimulus ----------------
   task automatic acc(input bit wr, input int cpu, input int rg, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1; bus_wr = wr; bus_cpu = CPU_W'(cpu); bus_reg = 3'(rg); bus_wdata = d;
      man_done = 0;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bus_en = 0; bus_wr = 0; bus_wdata = 0; man_done = 0;
      end
   endtask
   task automatic post(input int cpu, input logic [31:0] m, input logic [31:0] a, input logic [31:0] s, input logic [31:0] w);
      acc(1, cpu, 0, m); acc(1, cpu, 1, a); acc(1, cpu, 2, s); acc(1, cpu, 3, w); acc(0, cpu, 4, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1; n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1;
      idle(2);
      acc(0, 0, 5, 0); acc(0, 1, 4, 0);                 // R1 status zero
      // R2 R6 R9: range flush with notify
      post(0, 32'h0000_8002, 32'h1000, 32'h80, 32'hFF);
      idle(8);
      acc(0, 0, 5, 0); acc(0, 1, 5, 0);                 // R9 only issuer flagged
      acc(1, 0, 5, 4); acc(0, 0, 5, 0);                 // R10 clear
      // R3 R5 contention
      acc(1, 0, 0, 32'h1); acc(1, 1, 0, 32'h2); acc(1, 1, 1, 32'h5);
      acc(1, 0, 1, 32'h40); acc(1, 0, 2, 32'h40);
      acc(0, 1, 4, 0); acc(0, 0, 4, 0); acc(0, 1, 4, 0);
      // R7 way target, then whole-cache scope
      post(1, 32'h0040_8005, 32'h2000, 32'h100, 32'hF3);
      post(0, 32'h0002_0002, 32'h3000, 32'h200, 32'h0F);
      idle(12);
      // R4 R8 full queue
      auto_done = 0;
      for (int k = 0; k < 6; k++) begin acc(1, k % 2, 0, 32'h8000 | k); acc(0, k % 2, 4, 0); end
      acc(0, 0, 5, 0); acc(0, 1, 5, 0);
      acc(1, 0, 0, 32'h8001); man_done = 1;             // head leaves while commit meets a full queue
      acc(0, 0, 4, 0); man_done = 0;
      auto_done = 1; idle(40);
      // R10 set and clear in one cycle
      auto_done = 0;
      post(0, 32'h0000_8001, 32'h80, 32'h80, 0);
      idle(3);
      acc(1, 0, 5, 4); man_done = 1;
      acc(0, 0, 5, 0);
      acc(1, 0, 5, 0); acc(0, 0, 5, 0);
      acc(1, 0, 5, 4); acc(0, 0, 5, 0);
      // R9 no notify
      auto_done = 1;
      post(1, 32'h0000_0001, 32'h100, 32'h80, 0);
      idle(8); acc(0, 1, 5, 0);
      // R11 primitives
      auto_done = 0;
      post(0, 32'h0000_0002, 32'h400, 32'h80, 0);
      acc(1, 1, 6, 8); acc(0, 1, 6, 0);
      acc(1, 0, 6, 9); acc(1, 0, 6, 5); acc(0, 0, 6, 0);
      auto_done = 1; idle(10); acc(0, 0, 6, 0);
      // R2 unused index and shared reads
      acc(1, 0, 7, 123); acc(0, 0, 7, 0); acc(0, 0, 1, 0);
      idle(5);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule